// File: doc/BRIEF.md
# Low-Power Control Register Lock

This block keeps the low-power control word that software programs through a small register port in the fast clock domain. The word carries a hint asking that the next wait-for-interrupt enter low power, three clock enables that apply while in low power, one clock enable that applies while active, and an active-low main power-down flag. A write-enable driven only by hardware protects the word. It drops as soon as low-power entry starts and comes back when the device returns to the active state. Hardware also clears the hint on its own, either when a low-power transition starts or when a valid reset request is registered.

The slow clock domain never samples the fast-domain configuration directly. It keeps its last synchronized copies of the control word, the wakeup-enable mask and the reset-enable mask. Software writes 1 to a sync bit to start a request/acknowledge toggle handshake. The bit reads 1 until the handshake completes. After that, the slow-domain copies match the values that were present when the sync was written.

Top module: `lp_cfg_lock`

## Requirements
- R1: After reset the control word reads 0x180 (bits 7 and 8 set, all others 0), the write-enable reads 1, the sync bit reads 0, and the slow-domain copies are control 0x180, wakeup-enable 0 and reset-enable 0.
- R2: Address 0 holds the control word. Its writable bits are 0 (hint), 4, 5, 6, 7 and 8. The other bits always read 0. While the write-enable is 1, a write stores the data with those other bits cleared.
- R3: Address 2 reads the write-enable in bit 0. A software write to that address has no effect. A low-power entry event drives the write-enable to 0 on the next cycle.
- R4: A return-to-active event sets the write-enable back to 1 on the next cycle. When entry and return-to-active happen in the same cycle, entry takes priority and the write-enable becomes 0.
- R5: While the write-enable is 0, writes to the control word are ignored.
- R6: A low-power entry event or a reset-request event clears the hint bit (bit 0) on the next cycle. This clear wins over a write to the control word in the same cycle, and it takes effect even while the word is locked.
- R7: Writing 1 to bit 0 of address 1 starts a transfer. Bit 0 of address 1 reads 1 from the next cycle until the transfer completes and then reads 0. At that point the slow-domain copies equal the control word, wakeup-enable and reset-enable present at the sync write.
- R8: Without a sync, the slow-domain copies do not change, whatever happens to the fast-domain values.
- R9: A sync write while a transfer is in progress is ignored. It neither starts a second transfer nor changes the payload in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast (register) clock |
| rst_fast_n | input | 1 | Synchronous active-low reset, fast domain |
| clk_slow | input | 1 | Slow clock |
| rst_slow_n | input | 1 | Synchronous active-low reset, slow domain |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for write and read (0 control, 1 sync, 2 write-enable) |
| reg_wdata_i | input | 9 | Write data |
| reg_rdata_o | output | 9 | Read data for reg_addr_i (combinational) |
| wake_en_i | input | NUM_WAKE | Wakeup-enable mask in the fast domain |
| rst_en_i | input | NUM_RST | Reset-enable mask in the fast domain |
| lp_entry_i | input | 1 | Low-power entry has started (one-cycle event) |
| lp_exit_i | input | 1 | Returned to active state (one-cycle event) |
| rst_req_i | input | 1 | Valid reset request registered (one-cycle event) |
| ctrl_o | output | 9 | Current control word, fast domain |
| slow_ctrl_o | output | 9 | Synchronized control word, slow domain |
| slow_wake_en_o | output | NUM_WAKE | Synchronized wakeup-enable mask |
| slow_rst_en_o | output | NUM_RST | Synchronized reset-enable mask |

## Verification
A write-enable stuck in the wrong state appears at address 2 on the cycle after an event, and writes begin to land or vanish in the control word read on the cycle after that. If the handshake gets out of step, either the sync bit never clears, which shows up within a few slow-clock periods of polling, or the slow copies hold a value that differs from the one present at the sync write. A transfer accepted while another is busy corrupts the slow copy. That is visible after the first transfer completes.

// File: rtl/lpl_pkg.sv
// Shared constants for the low-power control register lock.
// Assumes a 9-bit control word whose bit positions are decoded by the
// power sequencer outside this block.
package lpl_pkg;
    localparam int CTRL_W   = 9;
    localparam int ADDR_W   = 2;
    localparam int HINT_BIT = 0;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h180;
    localparam logic [CTRL_W-1:0] CTRL_WMASK = 9'h1F1;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_SYNC  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_WE    = 2'd2;
endpackage

// File: rtl/lpl_bit_sync.sv
// Multi-flop synchronizer for one level/toggle signal.
// Assumes the input changes at most once per few destination cycles.
module lpl_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff_q;

    generate
        if (STAGES == 1) begin : g_one
            // Single stage capture.
            always_ff @(posedge clk) begin
                if (!rst_n) ff_q <= '0;
                else        ff_q <= d_i;
            end
        end else begin : g_chain
            // Shift the input through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) ff_q <= '0;
                else        ff_q <= {ff_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/lpl_ctrl_reg.sv
// Control word with its hardware-owned write-enable.
// Assumes entry/exit/reset-request are single-cycle events in this domain.
// Hint clear overrides a same-cycle software write; entry beats exit.
module lpl_ctrl_reg
    import lpl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    input  logic              lp_entry_i,
    input  logic              lp_exit_i,
    input  logic              rst_req_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              we_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              we_q;

    // Write-enable follows the power transition events only.
    always_ff @(posedge clk) begin
        if (!rst_n)          we_q <= 1'b1;
        else if (lp_entry_i) we_q <= 1'b0;
        else if (lp_exit_i)  we_q <= 1'b1;
    end

    // Software update when unlocked, then hardware hint clear on top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            if (wr_i && we_q) ctrl_q <= wdata_i & CTRL_WMASK;
            if (lp_entry_i || rst_req_i) ctrl_q[HINT_BIT] <= 1'b0;
        end
    end

    assign ctrl_o = ctrl_q;
    assign we_o   = we_q;

    p_lock_on_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lp_entry_i |=> !we_q);
    p_we_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lp_entry_i && !lp_exit_i) |=> $stable(we_q));
    p_unlock_on_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_exit_i && !lp_entry_i) |=> we_q);
    p_locked_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_q && !lp_entry_i && !rst_req_i) |=> $stable(ctrl_q));
    p_hint_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_entry_i || rst_req_i) |=> !ctrl_q[HINT_BIT]);
endmodule

// File: rtl/lpl_sync_tx.sv
// Fast-side half of the toggle handshake: launches a request, holds the
// payload until the acknowledge toggle returns, and rejects starts while busy.
module lpl_sync_tx #(
    parameter int PAY_W  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PAY_W-1:0] payload_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic [PAY_W-1:0] payload_o,
    output logic             busy_o
);
    logic             req_q;
    logic             ack_s;
    logic [PAY_W-1:0] hold_q;
    logic             busy;

    lpl_bit_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ack_i), .q_o(ack_s)
    );

    assign busy = req_q ^ ack_s;

    // Accept a start only when idle: flip the request and freeze the payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            hold_q <= '0;
        end else if (start_i && !busy) begin
            req_q  <= ~req_q;
            hold_q <= payload_i;
        end
    end

    assign req_o     = req_q;
    assign payload_o = hold_q;
    assign busy_o    = busy;

    p_payload_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(hold_q));
    p_start_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy) |=> $stable(req_q));
    p_start_goes_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> busy);
endmodule

// File: rtl/lpl_sync_rx.sv
// Slow-side half of the toggle handshake: on a new request toggle it
// captures the held payload and returns the acknowledge toggle.
// Assumes the payload is stable from request until acknowledge.
module lpl_sync_rx #(
    parameter int              PAY_W     = 16,
    parameter int              STAGES    = 2,
    parameter logic [PAY_W-1:0] PAY_RESET = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [PAY_W-1:0] payload_i,
    output logic             ack_o,
    output logic [PAY_W-1:0] data_o
);
    logic             req_s;
    logic             ack_q;
    logic [PAY_W-1:0] data_q;

    lpl_bit_sync #(.STAGES(STAGES)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d_i(req_i), .q_o(req_s)
    );

    // Capture once per request toggle and echo it as the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            data_q <= PAY_RESET;
        end else if (req_s != ack_q) begin
            ack_q  <= req_s;
            data_q <= payload_i;
        end
    end

    assign ack_o  = ack_q;
    assign data_o = data_q;

    p_no_request_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_s == ack_q) |=> $stable(data_q));
    p_ack_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_s != ack_q) |=> (ack_q == $past(req_s)));
endmodule

// File: rtl/lp_cfg_lock.sv
// Low-power control register lock: fast-domain register port, hardware
// write-enable, and a software-triggered transfer of control word plus
// wakeup/reset enable masks into the slow domain.
// Assumes both resets are released together and events are single-cycle.
module lp_cfg_lock
    import lpl_pkg::*;
#(
    parameter int NUM_WAKE    = 5,
    parameter int NUM_RST     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_fast,
    input  logic                rst_fast_n,
    input  logic                clk_slow,
    input  logic                rst_slow_n,
    input  logic                reg_wr_i,
    input  logic [ADDR_W-1:0]   reg_addr_i,
    input  logic [CTRL_W-1:0]   reg_wdata_i,
    output logic [CTRL_W-1:0]   reg_rdata_o,
    input  logic [NUM_WAKE-1:0] wake_en_i,
    input  logic [NUM_RST-1:0]  rst_en_i,
    input  logic                lp_entry_i,
    input  logic                lp_exit_i,
    input  logic                rst_req_i,
    output logic [CTRL_W-1:0]   ctrl_o,
    output logic [CTRL_W-1:0]   slow_ctrl_o,
    output logic [NUM_WAKE-1:0] slow_wake_en_o,
    output logic [NUM_RST-1:0]  slow_rst_en_o
);
    localparam int PAY_W = CTRL_W + NUM_WAKE + NUM_RST;
    localparam logic [PAY_W-1:0] PAY_RESET = {{(NUM_RST + NUM_WAKE){1'b0}}, CTRL_RESET};

    logic [CTRL_W-1:0] ctrl;
    logic              we;
    logic              busy;
    logic              req;
    logic              ack;
    logic              wr_ctrl;
    logic              sync_start;
    logic [PAY_W-1:0]  pay_fast;
    logic [PAY_W-1:0]  pay_slow;

    assign wr_ctrl    = reg_wr_i && (reg_addr_i == ADDR_CTRL);
    assign sync_start = reg_wr_i && (reg_addr_i == ADDR_SYNC) && reg_wdata_i[0];

    lpl_ctrl_reg u_ctrl (
        .clk(clk_fast), .rst_n(rst_fast_n),
        .wr_i(wr_ctrl), .wdata_i(reg_wdata_i),
        .lp_entry_i(lp_entry_i), .lp_exit_i(lp_exit_i), .rst_req_i(rst_req_i),
        .ctrl_o(ctrl), .we_o(we)
    );

    lpl_sync_tx #(.PAY_W(PAY_W), .STAGES(SYNC_STAGES)) u_tx (
        .clk(clk_fast), .rst_n(rst_fast_n),
        .start_i(sync_start), .payload_i({rst_en_i, wake_en_i, ctrl}),
        .ack_i(ack), .req_o(req), .payload_o(pay_fast), .busy_o(busy)
    );

    lpl_sync_rx #(.PAY_W(PAY_W), .STAGES(SYNC_STAGES), .PAY_RESET(PAY_RESET)) u_rx (
        .clk(clk_slow), .rst_n(rst_slow_n),
        .req_i(req), .payload_i(pay_fast),
        .ack_o(ack), .data_o(pay_slow)
    );

    // Register read mux.
    always_comb begin
        unique case (reg_addr_i)
            ADDR_CTRL: reg_rdata_o = ctrl;
            ADDR_SYNC: reg_rdata_o = {{(CTRL_W-1){1'b0}}, busy};
            ADDR_WE:   reg_rdata_o = {{(CTRL_W-1){1'b0}}, we};
            default:   reg_rdata_o = '0;
        endcase
    end

    assign ctrl_o         = ctrl;
    assign slow_ctrl_o    = pay_slow[CTRL_W-1:0];
    assign slow_wake_en_o = pay_slow[CTRL_W +: NUM_WAKE];
    assign slow_rst_en_o  = pay_slow[CTRL_W+NUM_WAKE +: NUM_RST];

    p_reserved_zero_r2: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
        (ctrl & ~CTRL_WMASK) == '0);
endmodule

// File: tb/sim_lp_cfg_lock.sv
`timescale 1ns/1ps
module sim_lp_cfg_lock;
    localparam int NW = 5;
    localparam int NR = 2;

    logic clk_fast = 0, clk_slow = 0;
    logic rst_fast_n = 0, rst_slow_n = 0;
    logic reg_wr_i = 0;
    logic [1:0] reg_addr_i = 0;
    logic [8:0] reg_wdata_i = 0;
    logic [8:0] reg_rdata_o;
    logic [NW-1:0] wake_en_i = 0;
    logic [NR-1:0] rst_en_i = 0;
    logic lp_entry_i = 0, lp_exit_i = 0, rst_req_i = 0;
    logic [8:0] ctrl_o, slow_ctrl_o;
    logic [NW-1:0] slow_wake_en_o;
    logic [NR-1:0] slow_rst_en_o;

    int checks = 0, fails = 0;
    logic [8:0] m_ctrl;
    logic       m_we;

    always #2.5 clk_fast = ~clk_fast;
    always #17  clk_slow = ~clk_slow;

    lp_cfg_lock u0 (
        .clk_fast(clk_fast), .rst_fast_n(rst_fast_n),
        .clk_slow(clk_slow), .rst_slow_n(rst_slow_n),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .wake_en_i(wake_en_i), .rst_en_i(rst_en_i),
        .lp_entry_i(lp_entry_i), .lp_exit_i(lp_exit_i), .rst_req_i(rst_req_i),
        .ctrl_o(ctrl_o), .slow_ctrl_o(slow_ctrl_o),
        .slow_wake_en_o(slow_wake_en_o), .slow_rst_en_o(slow_rst_en_o)
    );

    function automatic logic [8:0] f_ctrl(logic [8:0] cur, logic we, logic wr,
                                          logic [8:0] d, logic ent, logic rq);
        logic [8:0] n = cur;
        if (wr && we) n = d & 9'h1F1;
        if (ent || rq) n[0] = 1'b0;
        return n;
    endfunction

    function automatic logic f_we(logic cur, logic ent, logic ex);
        if (ent) return 1'b0;
        if (ex) return 1'b1;
        return cur;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [1:0] a, output logic [8:0] v);
        reg_wr_i = 0; reg_addr_i = a; #0.5; v = reg_rdata_o;
    endtask

    // One fast cycle of stimulus, model update, then inputs back to idle.
    task automatic step(logic wr, logic [1:0] a, logic [8:0] d,
                        logic ent, logic ex, logic rq);
        @(negedge clk_fast);
        reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d;
        lp_entry_i = ent; lp_exit_i = ex; rst_req_i = rq;
        m_ctrl = f_ctrl(m_ctrl, m_we, wr && a == 2'd0, d, ent, rq);
        m_we   = f_we(m_we, ent, ex);
        @(negedge clk_fast);
        reg_wr_i = 0; lp_entry_i = 0; lp_exit_i = 0; rst_req_i = 0;
    endtask

    task automatic check_regs(string tag);
        logic [8:0] v;
        rd(2'd0, v); check(tag, 16'(v), 16'(m_ctrl));
        rd(2'd2, v); check(tag, 16'(v), 16'(m_we));
    endtask

    task automatic wait_sync_done(string tag);
        logic [8:0] v;
        int n = 0;
        rd(2'd1, v);
        while (v[0] && n < 400) begin
            @(negedge clk_fast); rd(2'd1, v); n++;
        end
        check(tag, 16'(v), 16'h0);
    endtask

    initial begin
        #500_000;
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [8:0] v;
        logic [8:0] sa, sb;
        logic [NW-1:0] wa;
        logic [NR-1:0] ra;
        void'($urandom(32'd20240611));
        m_ctrl = 9'h180; m_we = 1'b1;
        repeat (4) @(posedge clk_slow);
        @(negedge clk_fast); rst_fast_n = 1; rst_slow_n = 1;
        @(negedge clk_fast);

        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", 16'(v), 16'h180);
        rd(2'd2, v); check("R1 we", 16'(v), 16'h1);
        rd(2'd1, v); check("R1 sync", 16'(v), 16'h0);
        check("R1 slow ctrl", 16'(slow_ctrl_o), 16'h180);
        check("R1 slow wake", 16'(slow_wake_en_o), 16'h0);
        check("R1 slow rst", 16'(slow_rst_en_o), 16'h0);

        // R2 writable mask
        step(1, 2'd0, 9'h1FF, 0, 0, 0); check_regs("R2 mask");
        check("R2 ctrl_o", 16'(ctrl_o), 16'h1F1);
        step(1, 2'd0, 9'h00E, 0, 0, 0); check_regs("R2 reserved");
        // R3 write-enable is read-only to software
        step(1, 2'd2, 9'h000, 0, 0, 0); check_regs("R3 we write ignored");
        // R6 reset request clears hint
        step(1, 2'd0, 9'h031, 0, 0, 0);
        step(0, 2'd0, 9'h0, 0, 0, 1); check_regs("R6 rst_req clears hint");
        // R6 entry with same-cycle write: write lands except hint; R3 locks
        step(1, 2'd0, 9'h0F1, 1, 0, 0); check_regs("R6 R3 entry+write");
        rd(2'd0, v); check("R6 hint cleared", 16'(v), 16'h0F0);
        // R5 locked write ignored
        step(1, 2'd0, 9'h101, 0, 0, 0); check_regs("R5 locked write");
        // R4 entry beats exit
        step(0, 2'd0, 9'h0, 1, 1, 0); check_regs("R4 entry priority");
        rd(2'd2, v); check("R4 still locked", 16'(v), 16'h0);
        step(0, 2'd0, 9'h0, 0, 1, 0); check_regs("R4 unlock");
        rd(2'd2, v); check("R4 unlocked", 16'(v), 16'h1);

        // Random mix of writes and events
        for (int i = 0; i < 300; i++) begin
            logic wr, ent, ex, rq;
            logic [1:0] a;
            logic [8:0] d;
            string tag;
            wr = 1'($urandom); a = $urandom_range(0, 1) == 0 ? 2'd0 : 2'd2;
            d = 9'($urandom);
            ent = ($urandom_range(0, 7) == 0); ex = ($urandom_range(0, 5) == 0);
            rq = ($urandom_range(0, 7) == 0);
            if (ent || rq) tag = "R6 random";
            else if (!m_we && wr) tag = "R5 random";
            else if (ex) tag = "R4 random";
            else tag = "R2 random";
            step(wr, a, d, ent, ex, rq);
            check_regs(tag);
        end

        // R8 no change without sync
        step(0, 2'd0, 9'h0, 0, 1, 0);
        step(1, 2'd0, 9'h0B0, 0, 0, 0);
        wake_en_i = 5'h15; rst_en_i = 2'h2;
        repeat (10) @(posedge clk_slow);
        @(negedge clk_fast);
        check("R8 slow ctrl held", 16'(slow_ctrl_o), 16'h180);
        check("R8 slow wake held", 16'(slow_wake_en_o), 16'h0);

        // R7 sync transfer
        sa = 9'h0B0; wa = 5'h15; ra = 2'h2;
        step(1, 2'd1, 9'h001, 0, 0, 0);
        rd(2'd1, v); check("R7 busy", 16'(v), 16'h1);
        wait_sync_done("R7 done");
        check("R7 slow ctrl", 16'(slow_ctrl_o), 16'(sa));
        check("R7 slow wake", 16'(slow_wake_en_o), 16'(wa));
        check("R7 slow rst", 16'(slow_rst_en_o), 16'(ra));

        // R9 second sync during transfer ignored
        for (int k = 0; k < 3; k++) begin
            sb = 9'($urandom) & 9'h1F0;
            wa = 5'($urandom); ra = 2'($urandom);
            step(1, 2'd0, sb, 0, 0, 0);
            wake_en_i = wa; rst_en_i = ra;
            step(1, 2'd1, 9'h001, 0, 0, 0);
            step(1, 2'd0, sb ^ 9'h1F0, 0, 0, 0);
            wake_en_i = ~wa; rst_en_i = ~ra;
            step(1, 2'd1, 9'h001, 0, 0, 0);
            wait_sync_done("R9 done");
            check("R9 slow ctrl", 16'(slow_ctrl_o), 16'(sb));
            check("R9 slow wake", 16'(slow_wake_en_o), 16'(wa));
            repeat (12) @(posedge clk_slow);
            @(negedge clk_fast);
            check("R9 R8 no second transfer", 16'(slow_ctrl_o), 16'(sb));
            check("R9 slow rst", 16'(slow_rst_en_o), 16'(ra));
        end

        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule